// File: doc/BRIEF.md
# Address Region Decoder with Per-Width Wait States

This block sits between a CPU-side request port and eight memory regions. It turns a 32-bit address into a one-hot select for the region that owns it and passes the low 24 address bits to that region as a local offset. It then holds the access open for a cycle count. That count depends on which region was hit and on whether the access is 8, 16 or 32 bits wide. When the count runs out, the block raises a one-cycle completion pulse and returns the selected region's read data. An address that falls in no region completes at once with an error flag.

A request is taken only while the block is idle, which `req_ready` signals. The select, offset and write data stay steady for the whole access. Writes aimed at either of the two read-only regions are decoded and timed like any other access, but they never produce a write strobe.

Top module: `bus_region_decoder`

## Requirements
- R1: Region select bit order and address ranges (inclusive) are: bit 0 boot ROM 0x0000_0000..0x0000_3FFF, bit 1 external work RAM 0x0200_0000..0x0203_FFFF, bit 2 internal work RAM 0x0300_0000..0x0300_7FFF, bit 3 I/O 0x0400_0000..0x0400_03FE, bit 4 palette RAM 0x0500_0000..0x0500_03FF, bit 5 video RAM 0x0600_0000..0x0601_7FFF, bit 6 object RAM 0x0700_0000..0x0700_03FF, bit 7 cartridge ROM 0x0800_0000..0x09FF_FFFF; exactly the owning bit is high from the cycle after acceptance through the completion cycle, and the select is zero otherwise.
- R2: `rgn_offset` equals bits 23:0 of the accepted address from the cycle after acceptance through completion.
- R3: An address outside every range completes with `resp_done` and `resp_error` high in the first cycle after acceptance, with `rgn_sel` zero, `resp_rdata` zero and no write strobe.
- R4: With N the wait count, `resp_done` rises in the Nth cycle after the accepting edge; N is 1 for regions 0..3 and 6 at any width, 1/1/2 for palette and video RAM (8/16/32-bit), and 5/5/8 for cartridge ROM.
- R5: `rgn_sel`, `rgn_offset` and `rgn_wdata` stay constant during an access even when new requests are presented.
- R6: `req_ready` is high exactly when idle; `resp_done` is a single-cycle pulse, and a request presented while busy is not taken.
- R7: In the completion cycle of a mapped access, `resp_rdata` equals the 32-bit word that the selected region drives on its slice `rgn_rdata[32*i +: 32]`.
- R8: `rgn_we` is high only in the completion cycle of a write to a region other than bit 0 or bit 7.
- R9: `req_size` encoding: 2'b00 is 8-bit, 2'b01 is 16-bit, 2'b10 and 2'b11 are 32-bit.
- R10: After reset, `req_ready` is 1 and `rgn_sel`, `resp_done`, `resp_error` and `rgn_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this edge |
| req_addr | input | 32 | Request address |
| req_size | input | 2 | Access width code |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | Write data |
| rgn_sel | output | 8 | One-hot region select |
| rgn_offset | output | 24 | Region-local offset |
| rgn_wdata | output | 32 | Write data to regions |
| rgn_we | output | 1 | Write strobe |
| rgn_rdata | input | 256 | Read data, 32 bits per region |
| resp_done | output | 1 | Access complete pulse |
| resp_error | output | 1 | Unmapped address with completion |
| resp_rdata | output | 32 | Read data at completion |

## Verification
The hardest situation to reach is a long cartridge access that keeps being offered fresh, conflicting requests while it waits. The select, offset and write data must stay put, and the follow-on request must not be taken at the completion edge. The stimulus keeps `req_valid` high with random addresses throughout the wait of many random transactions. It also aims directed accesses at the first and last byte of each range and at the byte just past it, such as 0x0400_03FF, so that the inclusive bounds are exercised at all three widths.

// File: rtl/busdec_pkg.sv
package busdec_pkg;
   localparam int NUM_RGN = 8;
   localparam int RG_BOOT = 0;
   localparam int RG_PAL  = 4;
   localparam int RG_VID  = 5;
   localparam int RG_CART = 7;
   localparam logic [NUM_RGN-1:0] READ_ONLY = 8'b1000_0001;

   function automatic logic [31:0] rgn_lo(input int i);
      case (i)
         0: rgn_lo = 32'h0000_0000;
         1: rgn_lo = 32'h0200_0000;
         2: rgn_lo = 32'h0300_0000;
         3: rgn_lo = 32'h0400_0000;
         4: rgn_lo = 32'h0500_0000;
         5: rgn_lo = 32'h0600_0000;
         6: rgn_lo = 32'h0700_0000;
         default: rgn_lo = 32'h0800_0000;
      endcase
   endfunction

   function automatic logic [31:0] rgn_hi(input int i);
      case (i)
         0: rgn_hi = 32'h0000_3FFF;
         1: rgn_hi = 32'h0203_FFFF;
         2: rgn_hi = 32'h0300_7FFF;
         3: rgn_hi = 32'h0400_03FE;
         4: rgn_hi = 32'h0500_03FF;
         5: rgn_hi = 32'h0601_7FFF;
         6: rgn_hi = 32'h0700_03FF;
         default: rgn_hi = 32'h09FF_FFFF;
      endcase
   endfunction
endpackage

// File: rtl/region_match.sv
module region_match
   import busdec_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_RGN-1:0] hit
);
   if (ADDR_W != 32) begin : g_bad_width
      $error("region_match needs a 32-bit address");
   end

   for (genvar i = 0; i < NUM_RGN; i++) begin : g_rgn
      localparam logic [31:0] LO = rgn_lo(i);
      localparam logic [31:0] HI = rgn_hi(i);
      if (LO == 32'h0) begin : g_zero_base
         assign hit[i] = (addr <= HI);
      end else begin : g_range
         assign hit[i] = (addr >= LO) && (addr <= HI);
      end
   end
endmodule

// File: rtl/wait_lookup.sv
module wait_lookup
   import busdec_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int FAST     = 1,
   parameter int VID_NARW = 1,
   parameter int VID_WIDE = 2,
   parameter int CART_NARW = 5,
   parameter int CART_WIDE = 8
) (
   input  logic [NUM_RGN-1:0] hit,
   input  logic [1:0]         size,
   output logic [CNT_W-1:0]   count
);
   localparam int MAXC = (CART_WIDE > VID_WIDE) ? CART_WIDE : VID_WIDE;

   if (MAXC >= (1 << CNT_W)) begin : g_cnt_small
      $error("CNT_W too narrow for the wait table");
   end
   if (FAST < 1 || VID_NARW < 1 || CART_NARW < 1) begin : g_zero_wait
      $error("wait counts must be at least one");
   end

   logic              wide;
   logic [CNT_W-1:0]  term [NUM_RGN];
   assign wide = size[1];

   for (genvar i = 0; i < NUM_RGN; i++) begin : g_tab
      if (i == RG_PAL || i == RG_VID) begin : g_video
         assign term[i] = hit[i] ? (wide ? CNT_W'(VID_WIDE) : CNT_W'(VID_NARW)) : '0;
      end else if (i == RG_CART) begin : g_cart
         assign term[i] = hit[i] ? (wide ? CNT_W'(CART_WIDE) : CNT_W'(CART_NARW)) : '0;
      end else begin : g_fast
         assign term[i] = hit[i] ? CNT_W'(FAST) : '0;
      end
   end

   always_comb begin
      count = '0;
      for (int i = 0; i < NUM_RGN; i++) count = count | term[i];
      if (hit == '0) count = CNT_W'(1);
   end
endmodule

// File: rtl/access_timer.sv
module access_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             last
);
   logic [CNT_W-1:0] remain;

   assign last = busy && (remain == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (load) begin
         busy   <= 1'b1;
         remain <= load_val;
      end else if (last) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (busy) begin
         remain <= remain - CNT_W'(1);
      end
   end

   a_r4_nonzero_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_val != '0));
   a_r6_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !load);
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !last);
   a_r6_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !busy);
endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
   import busdec_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int OFF_W     = 24,
   parameter int CNT_W     = 4,
   parameter int VID_WIDE  = 2,
   parameter int CART_NARW = 5,
   parameter int CART_WIDE = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [1:0]                req_size,
   input  logic                      req_write,
   input  logic [DATA_W-1:0]         req_wdata,
   output logic [NUM_RGN-1:0]        rgn_sel,
   output logic [OFF_W-1:0]          rgn_offset,
   output logic [DATA_W-1:0]         rgn_wdata,
   output logic                      rgn_we,
   input  logic [NUM_RGN*DATA_W-1:0] rgn_rdata,
   output logic                      resp_done,
   output logic                      resp_error,
   output logic [DATA_W-1:0]         resp_rdata
);
   if (OFF_W > ADDR_W) begin : g_bad_off
      $error("offset wider than address");
   end

   logic [NUM_RGN-1:0] hit;
   logic [CNT_W-1:0]   wait_n;
   logic               accept, busy, last;
   logic               err_q, wr_q;
   logic [DATA_W-1:0]  rd_term [NUM_RGN];

   assign req_ready = !busy;
   assign accept    = req_valid && !busy;

   region_match #(.ADDR_W(ADDR_W)) u_match (.addr(req_addr), .hit(hit));

   wait_lookup #(
      .CNT_W(CNT_W), .FAST(1), .VID_NARW(1), .VID_WIDE(VID_WIDE),
      .CART_NARW(CART_NARW), .CART_WIDE(CART_WIDE)
   ) u_wait (.hit(hit), .size(req_size), .count(wait_n));

   access_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(wait_n),
      .busy(busy), .last(last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rgn_sel    <= '0;
         rgn_offset <= '0;
         rgn_wdata  <= '0;
         err_q      <= 1'b0;
         wr_q       <= 1'b0;
      end else if (accept) begin
         rgn_sel    <= hit;
         rgn_offset <= req_addr[OFF_W-1:0];
         rgn_wdata  <= req_wdata;
         err_q      <= (hit == '0);
         wr_q       <= req_write;
      end else if (last) begin
         rgn_sel    <= '0;
         err_q      <= 1'b0;
         wr_q       <= 1'b0;
      end
   end

   assign resp_done  = last;
   assign resp_error = last && err_q;
   assign rgn_we     = last && wr_q && ((rgn_sel & ~READ_ONLY) != '0);

   for (genvar i = 0; i < NUM_RGN; i++) begin : g_rd
      assign rd_term[i] = rgn_sel[i] ? rgn_rdata[i*DATA_W +: DATA_W] : '0;
   end

   always_comb begin
      resp_rdata = '0;
      for (int i = 0; i < NUM_RGN; i++) resp_rdata = resp_rdata | rd_term[i];
   end

   a_r1_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rgn_sel));
   a_r1_sel_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (rgn_sel == '0));
   a_r5_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !resp_done) |=>
         ($stable(rgn_sel) && $stable(rgn_offset) && $stable(rgn_wdata)));
   a_r3_error_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
      resp_error |-> (rgn_sel == '0 && resp_rdata == '0 && !rgn_we));
   a_r8_rom_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_we |-> !(rgn_sel[RG_BOOT] || rgn_sel[RG_CART]));
   a_r8_we_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_we |-> resp_done);
endmodule

// File: tb/sim_bus_region_decoder.sv
`timescale 1ns/1ps
module sim_bus_region_decoder;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [31:0]  req_addr = '0;
   logic [1:0]   req_size = '0;
   logic         req_write = 1'b0;
   logic [31:0]  req_wdata = '0;
   logic [7:0]   rgn_sel;
   logic [23:0]  rgn_offset;
   logic [31:0]  rgn_wdata;
   logic         rgn_we;
   logic [255:0] rgn_rdata = '0;
   logic         resp_done, resp_error;
   logic [31:0]  resp_rdata;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   bus_region_decoder u0 (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_region(input logic [31:0] a);
      if (a <= 32'h0000_3FFF) return 0;
      if (a >= 32'h0200_0000 && a <= 32'h0203_FFFF) return 1;
      if (a >= 32'h0300_0000 && a <= 32'h0300_7FFF) return 2;
      if (a >= 32'h0400_0000 && a <= 32'h0400_03FE) return 3;
      if (a >= 32'h0500_0000 && a <= 32'h0500_03FF) return 4;
      if (a >= 32'h0600_0000 && a <= 32'h0601_7FFF) return 5;
      if (a >= 32'h0700_0000 && a <= 32'h0700_03FF) return 6;
      if (a >= 32'h0800_0000 && a <= 32'h09FF_FFFF) return 7;
      return 8;
   endfunction

   function automatic int exp_wait(input int r, input logic [1:0] sz);
      if (r == 4 || r == 5) return sz[1] ? 2 : 1;
      if (r == 7) return sz[1] ? 8 : 5;
      return 1;
   endfunction

   task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                         input logic [31:0] wd, input bit junk);
      int r, n, cyc;
      logic [7:0] esel;
      logic [31:0] erd;
      r = exp_region(a);
      n = exp_wait(r, sz);
      esel = (r < 8) ? 8'(1 << r) : 8'h00;
      @(negedge clk);
      for (int i = 0; i < 8; i++) rgn_rdata[i*32 +: 32] = {8'(i), 24'($urandom)};
      erd = (r < 8) ? rgn_rdata[r*32 +: 32] : 32'h0;
      chk(req_ready === 1'b1, "R6 ready when idle", 32'(req_ready), 32'h1);
      req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
      @(negedge clk);
      cyc = 1;
      if (junk) begin
         req_addr = $urandom; req_wdata = $urandom; req_write = ~wr;
      end else req_valid = 1'b0;
      while (resp_done !== 1'b1 && cyc < 20) begin
         chk(rgn_sel === esel && rgn_offset === a[23:0] && rgn_wdata === wd,
             "R5 held fields", {rgn_sel, rgn_offset}, {esel, a[23:0]});
         chk(req_ready === 1'b0 && rgn_we === 1'b0, "R6 busy, no strobe",
             {30'h0, req_ready, rgn_we}, 32'h0);
         @(negedge clk);
         cyc++;
         if (junk) req_addr = $urandom;
      end
      chk(cyc == n, "R4 wait length", 32'(cyc), 32'(n));
      chk(rgn_sel === esel, "R1 region select", 32'(rgn_sel), 32'(esel));
      chk(rgn_offset === a[23:0], "R2 offset", 32'(rgn_offset), 32'(a[23:0]));
      chk(resp_error === (r == 8), "R3 error flag", 32'(resp_error), 32'(r == 8));
      if (!wr || r == 8)
         chk(resp_rdata === erd, "R7 read data", resp_rdata, erd);
      chk(rgn_we === (wr && r != 8 && r != 0 && r != 7), "R8 write strobe",
          32'(rgn_we), 32'(wr && r != 8 && r != 0 && r != 7));
      req_valid = 1'b0;
      @(negedge clk);
      chk(resp_done === 1'b0 && req_ready === 1'b1 && rgn_sel === 8'h0,
          "R6 single pulse, back to idle", {resp_done, req_ready, rgn_sel}, 32'h100);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] edges [24];
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1 && rgn_sel === 8'h0 && resp_done === 1'b0 &&
          resp_error === 1'b0 && rgn_we === 1'b0, "R10 reset state",
          {req_ready, rgn_sel, resp_done, resp_error, rgn_we}, 32'h800);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) begin
         edges[3*i]   = busdec_pkg::rgn_lo(i);
         edges[3*i+1] = busdec_pkg::rgn_hi(i);
         edges[3*i+2] = busdec_pkg::rgn_hi(i) + 32'h1;
      end
      // R9: every size code on every boundary address
      for (int k = 0; k < 24; k++)
         for (int s = 0; s < 4; s++)
            access(edges[k], 2'(s), 1'b0, 32'h0, 1'b0);
      // R8: writes to read-only and writable regions
      access(32'h0000_0010, 2'b10, 1'b1, 32'hDEAD_BEEF, 1'b0);
      access(32'h0812_3456, 2'b10, 1'b1, 32'hCAFE_0001, 1'b1);
      access(32'h0300_0100, 2'b00, 1'b1, 32'h0000_00AA, 1'b0);
      access(32'hFFFF_FFFF, 2'b10, 1'b1, 32'h1234_5678, 1'b1);
      for (int t = 0; t < 600; t++) begin
         int pick;
         logic [31:0] a, span;
         pick = $urandom % 10;
         if (pick < 8) begin
            span = busdec_pkg::rgn_hi(pick) - busdec_pkg::rgn_lo(pick) + 32'h1;
            a = busdec_pkg::rgn_lo(pick) + ($urandom % span);
         end else a = $urandom;
         access(a, 2'($urandom), 1'($urandom), $urandom, 1'($urandom));
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule